// File: doc/BRIEF.md
# Serial Port Control Pin Manager

This block owns the three general control pins and the bit-clock pin of a synchronous serial port. It holds a small six-bit control register. The register has two flag bits, three pin-direction bits and a clock-source bit. From that register, the port mode (synchronous or asynchronous, normal or network) and the two transmitter enables, it works out the output value and output enable of every pin. It also tells the shift logic which bit clock to use.

Flag values never reach a pin straight from the register. A separate two-bit flag latch loads them on a boundary strobe from the external frame/slot generator. In normal mode that strobe is the frame start. In network mode it is the slot start. Register writes between boundaries therefore leave the pins steady. A software reset command clears the register and the latch, just as the hardware reset does.

Top module: `sp_ctl_pins`

## Requirements
- R1: A write (`cfg_we`) stores `cfg_wdata` into the control register on the next clock. The bit layout is: bit 0 = flag A value, bit 1 = flag B value, bit 2 = pin 0 direction, bit 3 = pin 1 direction, bit 4 = pin 2 direction, bit 5 = clock source (1 = internal).
- R2: The flag latch loads register bits [1:0] on the clock after a boundary and holds at all other times. The boundary is `frame_start` when `net_mode`=0 and `slot_start` when `net_mode`=1. The other strobe has no effect.
- R3: `sc_oe[0]` is 1 whenever `tx1_en`=1. Otherwise it equals the pin 0 direction bit, in both synchronous and asynchronous mode.
- R4: `sc_oe[1]` is 1 whenever `tx2_en`=1. Otherwise it equals the pin 1 direction bit.
- R5: `sc_oe[2]` equals the pin 2 direction bit alone, and `sc_out[2]` always carries `fs_in`.
- R6: Pin 0 and pin 1 outputs follow one rule. While the pin's transmitter is enabled, its output carries that transmitter's data (`tx1_dat` or `tx2_dat`). With the transmitter disabled in synchronous mode, the output carries the pin's flag latch bit. With the transmitter disabled in asynchronous mode, it carries `alt_out[i]`.
- R7: The clock source bit controls the bit-clock pin and the clock selects. When it is 1, `sck_oe`=1 and `sck_out`=`int_clk`. When it is 0, `sck_oe`=0 and `sck_out`=0. `tx_clk_sel` equals the bit. `rx_clk_sel` equals the bit ANDed with `sync_mode`.
- R8: The hardware reset (`rst_n`=0) clears the register and the flag latch. A `sw_rst` pulse does the same on the next clock and takes priority over a write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Software reset command, one cycle |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control register write data |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| net_mode | input | 1 | 1 = network (slot-timed flags), 0 = normal (frame-timed flags) |
| tx1_en | input | 1 | Transmitter 1 enable |
| tx2_en | input | 1 | Transmitter 2 enable |
| frame_start | input | 1 | Frame boundary strobe |
| slot_start | input | 1 | Time-slot boundary strobe |
| tx1_dat | input | 1 | Transmitter 1 serial data |
| tx2_dat | input | 1 | Transmitter 2 serial data |
| alt_out | input | 2 | Asynchronous-mode drive for pins 0 and 1 |
| fs_in | input | 1 | Frame sync drive for pin 2 |
| int_clk | input | 1 | Internal bit clock |
| sc_out | output | 3 | Control pin output values |
| sc_oe | output | 3 | Control pin output enables |
| sck_out | output | 1 | Bit-clock pin output value |
| sck_oe | output | 1 | Bit-clock pin output enable |
| tx_clk_sel | output | 1 | Transmit clock select, 1 = internal |
| rx_clk_sel | output | 1 | Receive clock select, 1 = internal |

## Verification
The bench aims at the wrong-strobe case. It pulses the slot strobe in normal mode and the frame strobe in network mode. A design that picks the wrong boundary would move a flag pin mid-frame.

It also writes the register between boundaries while a flag pin is being driven. A design without the flag latch would show the new value early.

Other cases are a transmitter enabled with its direction bit clear, where a design that trusts the bit would float a driven pin, and a software reset landing on a write, where the write must lose. The internal clock is also selected in asynchronous mode, where the receive side must stay on the external clock.

// File: rtl/sp_ctl_pins.sv
module sp_ctl_pins (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  input  logic       sync_mode,
  input  logic       net_mode,
  input  logic       tx1_en,
  input  logic       tx2_en,
  input  logic       frame_start,
  input  logic       slot_start,
  input  logic       tx1_dat,
  input  logic       tx2_dat,
  input  logic [1:0] alt_out,
  input  logic       fs_in,
  input  logic       int_clk,
  output logic [2:0] sc_out,
  output logic [2:0] sc_oe,
  output logic       sck_out,
  output logic       sck_oe,
  output logic       tx_clk_sel,
  output logic       rx_clk_sel
);
  logic [5:0] cfg_q;
  logic [1:0] flag_q;
  logic       boundary;

  assign boundary = net_mode ? slot_start : frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= '0;
    end else if (sw_rst) begin
      cfg_q  <= '0;
      flag_q <= '0;
    end else begin
      if (cfg_we)   cfg_q  <= cfg_wdata;
      if (boundary) flag_q <= cfg_q[1:0];
    end
  end

  assign sc_oe[0]  = tx1_en | cfg_q[2];
  assign sc_oe[1]  = tx2_en | cfg_q[3];
  assign sc_oe[2]  = cfg_q[4];

  assign sc_out[0] = tx1_en ? tx1_dat : (sync_mode ? flag_q[0] : alt_out[0]);
  assign sc_out[1] = tx2_en ? tx2_dat : (sync_mode ? flag_q[1] : alt_out[1]);
  assign sc_out[2] = fs_in;

  assign sck_oe     = cfg_q[5];
  assign sck_out    = cfg_q[5] & int_clk;
  assign tx_clk_sel = cfg_q[5];
  assign rx_clk_sel = cfg_q[5] & sync_mode;
endmodule

module sp_ctl_pins_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic       cfg_we,
  input logic [5:0] cfg_wdata,
  input logic       net_mode,
  input logic       frame_start,
  input logic       slot_start,
  input logic       tx1_en,
  input logic       tx2_en,
  input logic [5:0] cfg_q,
  input logic [1:0] flag_q,
  input logic [2:0] sc_oe,
  input logic       sck_oe,
  input logic       rx_clk_sel,
  input logic       tx_clk_sel
);
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !sw_rst |=> cfg_q == $past(cfg_wdata)); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst && !(net_mode ? slot_start : frame_start) |=> $stable(flag_q)); // R2
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst && (net_mode ? slot_start : frame_start) |=> flag_q == $past(cfg_q[1:0])); // R2
  AST_TX1_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    tx1_en |-> sc_oe[0]); // R3
  AST_TX2_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    tx2_en |-> sc_oe[1]); // R4
  AST_RX_SEL_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk_sel |-> tx_clk_sel && sck_oe); // R7
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> cfg_q == '0 && flag_q == '0); // R8
endmodule

bind sp_ctl_pins sp_ctl_pins_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .net_mode(net_mode), .frame_start(frame_start), .slot_start(slot_start),
  .tx1_en(tx1_en), .tx2_en(tx2_en), .cfg_q(cfg_q), .flag_q(flag_q),
  .sc_oe(sc_oe), .sck_oe(sck_oe), .rx_clk_sel(rx_clk_sel), .tx_clk_sel(tx_clk_sel)
);

// File: tb/tb_sp_ctl_pins.sv
module tb_sp_ctl_pins;
  logic clk = 0, rst_n = 0;
  logic sw_rst = 0, cfg_we = 0;
  logic [5:0] cfg_wdata = 0;
  logic sync_mode = 1, net_mode = 0, tx1_en = 0, tx2_en = 0;
  logic frame_start = 0, slot_start = 0, tx1_dat = 0, tx2_dat = 0;
  logic [1:0] alt_out = 0;
  logic fs_in = 0, int_clk = 0;
  logic [2:0] sc_out, sc_oe;
  logic sck_out, sck_oe, tx_clk_sel, rx_clk_sel;

  int tests = 0, fails = 0;
  int m_cfg = 0;
  int m_flag = 0;

  always #2.5 clk = ~clk;

  sp_ctl_pins dut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_cfg <= 0; m_flag <= 0; end
    else if (sw_rst) begin m_cfg <= 0; m_flag <= 0; end
    else begin
      if (cfg_we) m_cfg <= int'(cfg_wdata);
      if ((net_mode && slot_start) || (!net_mode && frame_start)) m_flag <= m_cfg % 4;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int scd0 = (m_cfg >> 2) & 1, scd1 = (m_cfg >> 3) & 1, scd2 = (m_cfg >> 4) & 1;
    int sckd = (m_cfg >> 5) & 1;
    int e0, e1;
    chk("R3 sc_oe0", int'(sc_oe[0]), (tx1_en || scd0) ? 1 : 0);
    chk("R4 sc_oe1", int'(sc_oe[1]), (tx2_en || scd1) ? 1 : 0);
    chk("R5 sc_oe2", int'(sc_oe[2]), scd2);
    chk("R5 sc_out2", int'(sc_out[2]), int'(fs_in));
    e0 = tx1_en ? int'(tx1_dat) : (sync_mode ? (m_flag & 1) : int'(alt_out[0]));
    e1 = tx2_en ? int'(tx2_dat) : (sync_mode ? (m_flag >> 1) : int'(alt_out[1]));
    chk("R6/R2 sc_out0", int'(sc_out[0]), e0);
    chk("R6/R2 sc_out1", int'(sc_out[1]), e1);
    chk("R7 sck_oe", int'(sck_oe), sckd);
    chk("R7 sck_out", int'(sck_out), sckd ? int'(int_clk) : 0);
    chk("R7 tx_clk_sel", int'(tx_clk_sel), sckd);
    chk("R7 rx_clk_sel", int'(rx_clk_sel), (sckd && sync_mode) ? 1 : 0);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();
    chk("R8 reset sc_oe", int'(sc_oe), 0);
    chk("R8 reset sck_oe", int'(sck_oe), 0);
    rst_n = 1;
    step();

    // R2: flag latch protects pins from register writes between boundaries
    sync_mode = 1; net_mode = 0;
    cfg_we = 1; cfg_wdata = 6'b001111; step(); cfg_we = 0;
    chk("R2 no early flag", int'(sc_out[1:0]), 0);
    slot_start = 1; step(); slot_start = 0;
    chk("R2 slot ignored in normal", int'(sc_out[1:0]), 0);
    frame_start = 1; step(); frame_start = 0;
    chk("R2 frame loads", int'(sc_out[1:0]), 3);
    net_mode = 1;
    cfg_we = 1; cfg_wdata = 6'b001100; step(); cfg_we = 0;
    frame_start = 1; step(); frame_start = 0;
    chk("R2 frame ignored in network", int'(sc_out[1:0]), 3);
    slot_start = 1; step(); slot_start = 0;
    chk("R2 slot loads", int'(sc_out[1:0]), 0);

    // R3/R4: transmitter forces output with direction bit clear
    cfg_we = 1; cfg_wdata = 6'b000000; step(); cfg_we = 0;
    tx1_en = 1; tx2_en = 1; tx1_dat = 1; tx2_dat = 0; step();
    chk("R3 tx1 forces oe", int'(sc_oe[0]), 1);
    chk("R4 tx2 forces oe", int'(sc_oe[1]), 1);
    chk("R6 tx1 data", int'(sc_out[0]), 1);
    tx1_en = 0; tx2_en = 0;

    // R7: internal clock in async mode
    sync_mode = 0;
    cfg_we = 1; cfg_wdata = 6'b100000; step(); cfg_we = 0;
    int_clk = 1; step();
    chk("R7 async rx stays external", int'(rx_clk_sel), 0);
    chk("R7 sck driven", int'(sck_out), 1);

    // R8: software reset beats write
    sw_rst = 1; cfg_we = 1; cfg_wdata = 6'b111111; step(); sw_rst = 0; cfg_we = 0;
    chk("R8 sw_rst over write", int'(sc_oe), 0);
    chk("R1/R8 sck cleared", int'(sck_oe), 0);

    // R1: register layout observed through pins
    cfg_we = 1; cfg_wdata = 6'b010100; step(); cfg_we = 0;
    chk("R1 layout oe", int'(sc_oe), 3'b101);

    for (int i = 0; i < 3000; i++) begin
      sw_rst      = ($urandom_range(0, 99) == 0);
      cfg_we      = ($urandom_range(0, 3) == 0);
      cfg_wdata   = 6'($urandom);
      sync_mode   = 1'($urandom);
      net_mode    = 1'($urandom);
      tx1_en      = ($urandom_range(0, 2) == 0);
      tx2_en      = ($urandom_range(0, 2) == 0);
      frame_start = ($urandom_range(0, 4) == 0);
      slot_start  = ($urandom_range(0, 2) == 0);
      tx1_dat     = 1'($urandom);
      tx2_dat     = 1'($urandom);
      alt_out     = 2'($urandom);
      fs_in       = 1'($urandom);
      int_clk     = 1'($urandom);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule